// File: doc/BRIEF.md
# Clock Source Select and Supervision Register

This block is one 8-bit control and status register on a simple synchronous register bus. Software uses it to turn the internal and the external clock generators on and off, to pick which of the two drives the system clock, and to run a clock monitor. The monitor raises a flag, and an optional interrupt, when either clock is reported inactive. The register guards each writable bit with an interlock. A bit can be set only once the bits it depends on are already in place. Hardware also forces several bits when a clock is lost, when a generator is switched off, or when the chip stops without keeping the oscillator running.

The generators report their stable status on two input pins. The activity detectors report a lost clock as a one-cycle pulse. The block drives the two generator enables, the clock-select line for an external glitch-free multiplexer, and an interrupt request. Each write and each forced condition is taken from the register state and the inputs present in a cycle, and it takes effect at the next rising clock edge. A forced condition always wins over a software write in the same cycle.

Top module: `clkSelMonReg`

## Requirements
- R1: At the register address, a read returns {monIrqEn, monFlag, monOn, clkSel, intOn, intStable, extOn, extStable}, with bit 7 first and bit 0 last. At any other address a read returns 0, and a write there changes nothing.
- R2: After reset the register reads 0x08: intOn is 1 and every other bit is 0.
- R3: The interrupt request is high exactly when monIrqEn and monFlag are both 1.
- R4: Writing 1 to monIrqEn (bit 7) takes effect only if monOn is already 1. monIrqEn becomes 0 at the edge after any cycle in which monOn is 0.
- R5: monFlag (bit 6) cannot be set by software. It becomes 1 at the edge after a cycle in which monOn is 1 and either lost pulse is high. It becomes 0 at the edge after a cycle in which monOn is 0.
- R6: monFlag is cleared by a write that carries 0 in bit 6, but only if the last register access before that write was a read that saw monFlag at 1. A read that sees monFlag at 0 cancels the pending clear, and any write uses it up. A lost pulse in the same cycle keeps the flag set.
- R7: Writing 1 to monOn (bit 5) takes effect only when intOn, intStable, extOn and extStable are all 1 in that cycle. Writing 0 clears it.
- R8: monOn is forced to 1 while monFlag is 1. It is forced to 0 when intOn or extOn is 0, or when the stop input is high while the oscillator-in-stop input is low. A forced 0 wins over a forced 1.
- R9: clkSel (bit 4) = 1 selects the external clock. Writing 1 needs extOn and extStable to be 1. Writing 0 needs intOn and intStable to be 1. A write that fails this check leaves clkSel unchanged.
- R10: clkSel is forced to 1 by an internal-lost pulse or by intOn = 0. It is forced to 0 by an external-lost pulse or by extOn = 0. The forced 0 wins when both apply.
- R11: intStable (bit 2) and extStable (bit 0) show the stable inputs one cycle late. Software writes to bits 2, 0 and 6 are ignored.
- R12: A forced condition overrides a software write to the same bit in the same cycle. Both take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register bus address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of the read strobe |
| intStableIn | input | 1 | Internal generator reports a stable clock |
| extStableIn | input | 1 | External generator reports a stable clock |
| intLostIn | input | 1 | One-cycle pulse: internal clock found inactive |
| extLostIn | input | 1 | One-cycle pulse: external clock found inactive |
| stopMode | input | 1 | Chip is in stop mode |
| oscInStop | input | 1 | Oscillator is kept running during stop |
| intGenEn | output | 1 | Enable for the internal clock generator |
| extGenEn | output | 1 | Enable for the external clock generator |
| clkSelExt | output | 1 | 1 selects the external clock, 0 the internal clock |
| monIrq | output | 1 | Clock monitor interrupt request |

## Verification
The assertions assume that all inputs are synchronous to clk, that read and write strobes never occur in the same cycle, and that the lost indications are pulses sampled once per cycle. Both the directed stimulus and the random stimulus drive every input just after the falling edge and keep the read and write strobes exclusive. The random phase fires the lost pulses and the stop request only rarely. This lets the register get through its interlocks and reach the armed and forced states, rather than sitting in a permanently forced state.

// File: rtl/clkSelMonPkg.sv
package clkSelMonPkg;
  localparam int REG_W = 8;
  localparam int B_IRQEN = 7;
  localparam int B_FLAG = 6;
  localparam int B_MON = 5;
  localparam int B_SEL = 4;
  localparam int B_ION = 3;
  localparam int B_IST = 2;
  localparam int B_EON = 1;
  localparam int B_EST = 0;

  typedef struct packed {
    logic             rdHit;
    logic             wrHit;
    logic             clrFlag;
    logic [REG_W-1:0] wrData;
  } busStb_t;
endpackage

// File: rtl/clkSelMonCtrl.sv
module clkSelMonCtrl
  import clkSelMonPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_ADDR = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              flagNow,
  output busStb_t           stb
);
  localparam logic [ADDR_W-1:0] MY_ADDR = REG_ADDR[ADDR_W-1:0];

  logic hit;
  logic armed;

  assign hit = (busAddr == MY_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (busWr && hit) begin
      armed <= 1'b0;
    end else if (busRd && hit) begin
      armed <= flagNow;
    end
  end

  always_comb begin
    stb.rdHit   = busRd & hit;
    stb.wrHit   = busWr & hit;
    stb.wrData  = busWdata;
    stb.clrFlag = busWr & hit & armed & ~busWdata[B_FLAG];
  end

  // R6: the clear is armed only by a read that saw the flag set
  a_r6_arm_by_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(busRd && hit && flagNow));
  // R6: any write to the register uses the arm up
  a_r6_write_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && hit) |=> !armed);
endmodule

// File: rtl/clkSelMonDp.sv
module clkSelMonDp
  import clkSelMonPkg::*;
#(
  parameter bit RESET_INT_ON = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  busStb_t          stb,
  input  logic             intStableIn,
  input  logic             extStableIn,
  input  logic             intLostIn,
  input  logic             extLostIn,
  input  logic             stopMode,
  input  logic             oscInStop,
  output logic [REG_W-1:0] image,
  output logic             flagNow,
  output logic             intOn,
  output logic             extOn,
  output logic             clkSel,
  output logic             irqOut
);
  logic irqEn, flag, monOn, intSt, extSt;
  logic irqEnN, flagN, monOnN, selN, intOnN, extOnN;
  logic allOk, intOk, extOk;
  logic monForceClr, selForceSet, selForceClr;
  logic [REG_W-1:0] d;

  assign d = stb.wrData;
  assign intOk = intOn & intSt;
  assign extOk = extOn & extSt;
  assign allOk = intOk & extOk;
  assign monForceClr = ~intOn | ~extOn | (stopMode & ~oscInStop);
  assign selForceClr = extLostIn | ~extOn;
  assign selForceSet = intLostIn | ~intOn;

  // generator enables: plain software bits
  always_comb begin
    intOnN = stb.wrHit ? d[B_ION] : intOn;
    extOnN = stb.wrHit ? d[B_EON] : extOn;
  end

  // monitor on: forced clear, then forced set by flag, then gated write
  always_comb begin
    if (monForceClr) begin
      monOnN = 1'b0;
    end else if (flag) begin
      monOnN = 1'b1;
    end else if (stb.wrHit) begin
      monOnN = d[B_MON] ? (allOk | monOn) : 1'b0;
    end else begin
      monOnN = monOn;
    end
  end

  // monitor flag: hardware set, armed software clear
  always_comb begin
    if (!monOn) begin
      flagN = 1'b0;
    end else if (intLostIn || extLostIn) begin
      flagN = 1'b1;
    end else if (stb.clrFlag) begin
      flagN = 1'b0;
    end else begin
      flagN = flag;
    end
  end

  // interrupt enable: only alive while monitor on
  always_comb begin
    if (!monOn) begin
      irqEnN = 1'b0;
    end else if (stb.wrHit) begin
      irqEnN = d[B_IRQEN];
    end else begin
      irqEnN = irqEn;
    end
  end

  // clock select: forced clear beats forced set beats write
  always_comb begin
    if (selForceClr) begin
      selN = 1'b0;
    end else if (selForceSet) begin
      selN = 1'b1;
    end else if (stb.wrHit) begin
      if (d[B_SEL]) begin
        selN = extOk ? 1'b1 : clkSel;
      end else begin
        selN = intOk ? 1'b0 : clkSel;
      end
    end else begin
      selN = clkSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn  <= 1'b0;
      flag   <= 1'b0;
      monOn  <= 1'b0;
      clkSel <= 1'b0;
      intOn  <= RESET_INT_ON;
      extOn  <= 1'b0;
      intSt  <= 1'b0;
      extSt  <= 1'b0;
    end else begin
      irqEn  <= irqEnN;
      flag   <= flagN;
      monOn  <= monOnN;
      clkSel <= selN;
      intOn  <= intOnN;
      extOn  <= extOnN;
      intSt  <= intStableIn;
      extSt  <= extStableIn;
    end
  end

  always_comb begin
    image = '0;
    image[B_IRQEN] = irqEn;
    image[B_FLAG]  = flag;
    image[B_MON]   = monOn;
    image[B_SEL]   = clkSel;
    image[B_ION]   = intOn;
    image[B_IST]   = intSt;
    image[B_EON]   = extOn;
    image[B_EST]   = extSt;
  end

  assign flagNow = flag;
  assign irqOut = irqEn & flag;

  // R4: enable only rises while the monitor was on
  a_r4_irqen_needs_mon: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqEn) |-> $past(monOn));
  // R5: flag only rises from a lost pulse with monitor on
  a_r5_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(monOn && (intLostIn || extLostIn)));
  // R7: monitor turns on only with both generators ready, or forced by the flag
  a_r7_mon_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(monOn) |-> $past(allOk || flag));
  // R8: a set flag keeps the monitor on unless a clear is forced
  a_r8_flag_holds_mon: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !monForceClr) |=> monOn);
  // R10: a forced clear of the select always wins
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (extLostIn || !extOn) |=> !clkSel);
  // R9: the select rises only through a ready external clock or a forced set
  a_r9_sel_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSel) |-> $past(extOk || intLostIn || !intOn));
  // R11: stable bits follow their inputs one cycle late
  a_r11_stable_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (intSt == $past(intStableIn)) && (extSt == $past(extStableIn)));
endmodule

// File: rtl/clkSelMonReg.sv
module clkSelMonReg
  import clkSelMonPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_ADDR = 16,
  parameter bit RESET_INT_ON = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              intStableIn,
  input  logic              extStableIn,
  input  logic              intLostIn,
  input  logic              extLostIn,
  input  logic              stopMode,
  input  logic              oscInStop,
  output logic              intGenEn,
  output logic              extGenEn,
  output logic              clkSelExt,
  output logic              monIrq
);
  busStb_t          stb;
  logic             flagNow;
  logic [REG_W-1:0] image;

  clkSelMonCtrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .flagNow(flagNow), .stb(stb)
  );

  clkSelMonDp #(.RESET_INT_ON(RESET_INT_ON)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .intStableIn(intStableIn), .extStableIn(extStableIn),
    .intLostIn(intLostIn), .extLostIn(extLostIn),
    .stopMode(stopMode), .oscInStop(oscInStop),
    .image(image), .flagNow(flagNow), .intOn(intGenEn), .extOn(extGenEn),
    .clkSel(clkSelExt), .irqOut(monIrq)
  );

  assign busRdata = stb.rdHit ? image : '0;

  // R3: request follows enable and flag together
  a_r3_irq_pair: assert property (@(posedge clk) disable iff (!rstN)
    monIrq |-> (image[B_IRQEN] && image[B_FLAG]));
  // R1: reads away from the register return zero
  a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdHit |-> (busRdata == '0));
endmodule

// File: tb/test_clkSelMonReg.sv
module test_clkSelMonReg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic intStableIn = 1'b0, extStableIn = 1'b0;
  logic intLostIn = 1'b0, extLostIn = 1'b0;
  logic stopMode = 1'b0, oscInStop = 1'b1;
  logic intGenEn, extGenEn, clkSelExt, monIrq;

  localparam logic [7:0] REGA = 8'h10;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  bit mIe, mFl, mMon, mSel, mIOn, mISt, mEOn, mESt, mArm;

  clkSelMonReg i_clkSelMonReg (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata),
    .intStableIn(intStableIn), .extStableIn(extStableIn),
    .intLostIn(intLostIn), .extLostIn(extLostIn),
    .stopMode(stopMode), .oscInStop(oscInStop),
    .intGenEn(intGenEn), .extGenEn(extGenEn),
    .clkSelExt(clkSelExt), .monIrq(monIrq)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] mImage();
    return {mIe, mFl, mMon, mSel, mIOn, mISt, mEOn, mESt};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    {mIe, mFl, mMon, mSel, mEOn, mISt, mESt, mArm} = '0;
    mIOn = 1'b1;
  endtask

  task automatic modelStep();
    bit wrH, rdH, ie, fl, mon, sel, ion, eon, clr;
    wrH = busWr && (busAddr == REGA);
    rdH = busRd && (busAddr == REGA);
    clr = wrH && mArm && !busWdata[6];
    ion = wrH ? busWdata[3] : mIOn;
    eon = wrH ? busWdata[1] : mEOn;
    if (!mIOn || !mEOn || (stopMode && !oscInStop)) mon = 0;
    else if (mFl) mon = 1;
    else if (wrH && busWdata[5]) mon = mMon || (mIOn && mISt && mEOn && mESt);
    else if (wrH) mon = 0;
    else mon = mMon;
    if (!mMon) fl = 0;
    else if (intLostIn || extLostIn) fl = 1;
    else if (clr) fl = 0;
    else fl = mFl;
    if (!mMon) ie = 0;
    else if (wrH) ie = busWdata[7];
    else ie = mIe;
    if (extLostIn || !mEOn) sel = 0;
    else if (intLostIn || !mIOn) sel = 1;
    else if (wrH && busWdata[4] && mEOn && mESt) sel = 1;
    else if (wrH && !busWdata[4] && mIOn && mISt) sel = 0;
    else sel = mSel;
    if (wrH) mArm = 0;
    else if (rdH) mArm = mFl;
    mIe = ie; mFl = fl; mMon = mon; mSel = sel; mIOn = ion; mEOn = eon;
    mISt = intStableIn; mESt = extStableIn;
  endtask

  // one bus cycle, started just after a falling edge
  task automatic tick();
    #3;
    chk("R3 irq", {7'd0, monIrq}, {7'd0, mIe && mFl});
    chk("R9 clksel", {7'd0, clkSelExt}, {7'd0, mSel});
    chk("R1 genEn", {6'd0, intGenEn, extGenEn}, {6'd0, mIOn, mEOn});
    chk("R1 rdata", busRdata, (busRd && busAddr == REGA) ? mImage() : 8'h00);
    @(posedge clk);
    if (rstN) modelStep(); else modelReset();
    @(negedge clk);
    busRd = 0; busWr = 0; intLostIn = 0; extLostIn = 0; busAddr = REGA;
  endtask

  task automatic wr(input logic [7:0] v);
    busAddr = REGA; busWr = 1; busWdata = v; tick();
  endtask

  task automatic rdExp(input logic [7:0] exp, input string tag);
    busAddr = REGA; busRd = 1; #1;
    chk(tag, busRdata, exp);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    repeat (3) tick();
    rstN = 1;
    rdExp(8'h08, "R2 reset value");
    wr(8'hFF);
    intStableIn = 1; extStableIn = 1;
    tick();
    rdExp(8'h0F, "R7 R9 R4 R11 gated writes");
    wr(8'h2A);
    rdExp(8'h2F, "R7 monitor on");
    wr(8'hAA);
    rdExp(8'hAF, "R4 irq enable");
    extLostIn = 1; tick();
    wr(8'h8A);
    rdExp(8'hEF, "R5 R8 R6 flag set unarmed");
    chk("R3 irq high", {7'd0, monIrq}, 8'h01);
    wr(8'hAA);
    rdExp(8'hAF, "R6 armed clear");
    intLostIn = 1; tick();
    wr(8'hBA);
    rdExp(8'hFF, "R6 disarmed by clear read R10 forced set");
    wr(8'hAA);
    rdExp(8'hAF, "R9 write select internal");
    wr(8'hBA);
    intLostIn = 1; extLostIn = 1; tick();
    rdExp(8'hEF, "R10 clear wins");
    stopMode = 1; oscInStop = 0; tick(); tick();
    stopMode = 0; oscInStop = 1;
    rdExp(8'h0F, "R8 stop clears monitor R4 R5");
    wr(8'h08); tick();
    rdExp(8'h0D, "R8 ext off");
    wr(8'h0A);
    busWr = 1; busWdata = 8'h1A; extLostIn = 1; tick();
    rdExp(8'h0F, "R12 force beats write");
    busAddr = 8'h11; busWr = 1; busWdata = 8'hFF; tick();
    busAddr = 8'h11; busRd = 1; #1; chk("R1 other address read", busRdata, 8'h00); tick();
    rdExp(8'h0F, "R1 other address write ignored");
    intStableIn = 0; tick();
    rdExp(8'h0B, "R11 stable follows input");
    intStableIn = 1; tick();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 15);
      busAddr = ($urandom_range(0, 7) == 0) ? 8'h11 : REGA;
      if (r < 4) begin busWr = 1; busWdata = 8'($urandom()) | 8'h0A; end
      else if (r == 4) begin busWr = 1; busWdata = 8'($urandom()); end
      else if (r < 9) busRd = 1;
      intLostIn = ($urandom_range(0, 31) == 0);
      extLostIn = ($urandom_range(0, 31) == 0);
      if ($urandom_range(0, 63) == 0) begin stopMode = ~stopMode; oscInStop = $urandom(); end
      if ($urandom_range(0, 31) == 0) intStableIn = ~intStableIn;
      if ($urandom_range(0, 31) == 0) extStableIn = ~extStableIn;
      tick();
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule